// File: doc/BRIEF.md
# Single-Wire Wake and Auto-Sleep Sequencer

This block decides when a single-wire bus slave is powered and answering. It starts asleep and watches the line. A low pulse that lasts at least a deglitch window, and that begins with a falling edge seen while asleep, wakes it. It then holds the core logic in reset for a fixed power-up delay. It does not wait for the line to go high again. At the end of that delay it latches the default settings from the configuration bits, releases the core reset, and pulls the line low for a ready break whose width is 1.391 bit-times. The bit-time comes from the speed code it has just loaded.

While awake, the block times how long the line has gone without a transition, and it returns to sleep after a timeout whether the line rests high or low. An effective auto-sleep enable gates that timeout. The enable is the AND of a permit bit in the configuration, which disables auto-sleep for good, and a control bit the core can write. The control bit is set again by every load. A sleep command makes the block sleep on the next clock. A soft-reset command re-runs the load with its own shorter delay and then sends a new ready break. The line driver is open-drain, modelled as a pull-low enable, and the sleep output lets other logic be gated.

Top module: `wake_sleep_seq`

## Requirements
- R1: After reset `sleep`=1, `core_rst`=1 and `line_drive_low`=0.
- R2: While asleep, a low run on `line_in` shorter than DG_CYC clock samples does not wake the block, and a run of DG_CYC samples does.
- R3: `line_drive_low` rises DG_CYC+POR_CYC clock edges after the first edge that samples the line low, whether the host has released the line by then or not.
- R4: The ready break lasts round(1.391*BT) cycles, with BT = BT_SLOW_CYC >> spd. The 2-bit speed code spd is taken from `cfg_bits[1:0]` at load and is shown on `spd_code`.
- R5: `core_rst` is already 0 in the first cycle of the ready break.
- R6: While awake with auto-sleep on, `sleep` rises between IDLE_CYC and IDLE_CYC+1 edges after the edge that samples the last line transition. This holds whether the line rests high or low.
- R7: A write with `ctl_wr`=1 and `ctl_aslp`=0 while awake turns `aslp_on` off, and the block then never times out.
- R8: If `cfg_bits[2]` is 0 at load, `aslp_on` stays 0 even after a write of 1 to the control bit, and no timeout happens.
- R9: Every load, at power-up or soft reset, sets the control bit back to 1, so `aslp_on` equals `cfg_bits[2]`.
- R10: `sleep_cmd` while awake puts the block to sleep on the next edge, and it takes priority over `soft_rst_cmd` in the same cycle.
- R11: `soft_rst_cmd` while awake raises `line_drive_low` SRST_CYC+1 edges after the command is applied.
- R12: If the line is low when sleep is entered, it does not wake the block however long it stays low. A later rise and a qualified low pulse do wake it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| line_in | input | 1 | Sampled level of the bus line |
| cfg_bits | input | SPD_W+1 | Configuration: speed code in the low bits, auto-sleep permit on top |
| ctl_wr | input | 1 | Write strobe for the auto-sleep control bit |
| ctl_aslp | input | 1 | Value written to the auto-sleep control bit |
| sleep_cmd | input | 1 | Sleep opcode decoded |
| soft_rst_cmd | input | 1 | Soft-reset instruction decoded |
| line_drive_low | output | 1 | Open-drain enable that pulls the line low |
| sleep | output | 1 | Block is asleep |
| core_rst | output | 1 | Reset held on the core logic |
| aslp_on | output | 1 | Effective auto-sleep enable |
| spd_code | output | SPD_W | Loaded speed code |

## Verification
The bench probes the deglitch boundary one sample below and at the window. A filter that is off by one wakes on noise or needs one sample too many. It holds the wake pulse past the ready break, which catches a sequencer that waits for the line to rise. It holds the line low across entry to sleep, which catches a design that wakes on a level instead of on a qualified fall. The bench measures every speed code's break width, both idle levels, the disable paths from control and from configuration, the re-arming after soft reset, and a sleep command and a soft reset given together. Errors there show up as a wrong pulse width, a missed or spurious timeout, or a sleep that never happens.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_PWRUP = 2'd1,
    ST_BRK   = 2'd2,
    ST_AWAKE = 2'd3
  } wsq_state_e;

  // Ready-break width: 1.391 bit-times, rounded to nearest cycle, at least 1.
  function automatic int brk_len(int bt);
    int r;
    r = (bt * 1391 + 500) / 1000;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/wsq_deglitch.sv
module wsq_deglitch #(
  parameter int DG_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line,
  output logic qual
);
  localparam int CW = $clog2(DG_CYC + 1);

  logic          armed;
  logic [CW-1:0] lo_cnt;

  // Armed only after a high level is seen while enabled: a fall is required.
  always_ff @(posedge clk) begin
    if (rst || !en) armed <= 1'b0;
    else if (line)  armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || line)                          lo_cnt <= '0;
    else if (armed && lo_cnt != CW'(DG_CYC))         lo_cnt <= lo_cnt + 1'b1;
  end

  assign qual = en && armed && !line && (lo_cnt == CW'(DG_CYC - 1));
endmodule

// File: rtl/wsq_brkgen.sv
module wsq_brkgen #(
  parameter int BT_SLOW_CYC = 64,
  parameter int SPD_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SPD_W-1:0] spd,
  output logic             busy,
  output logic             last
);
  localparam int NSPD = 1 << SPD_W;
  localparam int LW   = $clog2(wsq_pkg::brk_len(BT_SLOW_CYC) + 1);

  logic [LW-1:0] len_tab [NSPD];
  logic [LW-1:0] cnt;

  for (genvar i = 0; i < NSPD; i++) begin : g_len
    localparam int LEN = wsq_pkg::brk_len(BT_SLOW_CYC >> i);
    assign len_tab[i] = LW'(LEN);
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= len_tab[spd];
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == LW'(1));
endmodule

// File: rtl/wsq_idle.sv
module wsq_idle #(
  parameter int IDLE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic en,
  input  logic line,
  output logic tmo
);
  localparam int IW = $clog2(IDLE_CYC);

  logic          line_prev;
  logic          chg;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) line_prev <= 1'b0;
    else     line_prev <= line;
  end

  assign chg = (line != line_prev);

  always_ff @(posedge clk) begin
    if (rst || !run || chg)              cnt <= '0;
    else if (cnt != IW'(IDLE_CYC - 1))   cnt <= cnt + 1'b1;
  end

  assign tmo = run && en && !chg && (cnt == IW'(IDLE_CYC - 1));
endmodule

// File: rtl/wake_sleep_seq.sv
module wake_sleep_seq #(
  parameter int DG_CYC      = 8,
  parameter int POR_CYC     = 10,
  parameter int SRST_CYC    = 12,
  parameter int IDLE_CYC    = 200,
  parameter int BT_SLOW_CYC = 64,
  parameter int SPD_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [SPD_W:0]   cfg_bits,
  input  logic             ctl_wr,
  input  logic             ctl_aslp,
  input  logic             sleep_cmd,
  input  logic             soft_rst_cmd,
  output logic             line_drive_low,
  output logic             sleep,
  output logic             core_rst,
  output logic             aslp_on,
  output logic [SPD_W-1:0] spd_code
);
  import wsq_pkg::*;

  localparam int MAXD = (POR_CYC > SRST_CYC) ? POR_CYC : SRST_CYC;
  localparam int TW   = $clog2(MAXD + 1);

  wsq_state_e       state;
  logic [TW-1:0]    tmr;
  logic [SPD_W-1:0] spd_q;
  logic             cfg_aslp_q;
  logic             ctl_aslp_q;
  logic             qual, brk_busy, brk_last, tmo, load;

  assign load = (state == ST_PWRUP) && (tmr == '0);

  wsq_deglitch #(.DG_CYC(DG_CYC)) u_dg (
    .clk(clk), .rst(rst), .en(state == ST_SLEEP), .line(line_in), .qual(qual)
  );

  wsq_brkgen #(.BT_SLOW_CYC(BT_SLOW_CYC), .SPD_W(SPD_W)) u_brk (
    .clk(clk), .rst(rst), .start(load), .spd(cfg_bits[SPD_W-1:0]),
    .busy(brk_busy), .last(brk_last)
  );

  wsq_idle #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .run(state == ST_AWAKE), .en(aslp_on),
    .line(line_in), .tmo(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SLEEP;
      tmr        <= '0;
      spd_q      <= '0;
      cfg_aslp_q <= 1'b0;
      ctl_aslp_q <= 1'b1;
    end else begin
      case (state)
        ST_SLEEP: if (qual) begin
          state <= ST_PWRUP;
          tmr   <= TW'(POR_CYC - 1);
        end
        ST_PWRUP: if (load) begin
          state      <= ST_BRK;
          spd_q      <= cfg_bits[SPD_W-1:0];
          cfg_aslp_q <= cfg_bits[SPD_W];
          ctl_aslp_q <= 1'b1;
        end else begin
          tmr <= tmr - 1'b1;
        end
        ST_BRK: if (brk_last) state <= ST_AWAKE;
        default: begin
          if (sleep_cmd || tmo) begin
            state <= ST_SLEEP;
          end else if (soft_rst_cmd) begin
            state <= ST_PWRUP;
            tmr   <= TW'(SRST_CYC - 1);
          end else if (ctl_wr) begin
            ctl_aslp_q <= ctl_aslp;
          end
        end
      endcase
    end
  end

  assign line_drive_low = brk_busy;
  assign sleep          = (state == ST_SLEEP);
  assign core_rst       = (state == ST_SLEEP) || (state == ST_PWRUP);
  assign aslp_on        = cfg_aslp_q & ctl_aslp_q;
  assign spd_code       = spd_q;
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic sleep_cmd,
  input logic line_drive_low,
  input logic sleep,
  input logic core_rst,
  input logic aslp_on
);
  // R1 / R10: no break is driven while asleep
  assert_no_drive_asleep_R1: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !line_drive_low);

  // R5: a break starts only out of the power-up phase
  assert_brk_after_pwrup_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(line_drive_low) |-> $past(core_rst));

  // R5: core reset is released exactly as the break begins
  assert_rst_release_brk_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> line_drive_low);

  // R2: leaving sleep needs the line sampled low
  assert_wake_on_low_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !$past(line_in));

  // R10: sleep command while fully awake sleeps on the next edge
  assert_sleep_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    (sleep_cmd && !sleep && !core_rst && !line_drive_low) |=> sleep);

  // R7 / R8: with auto-sleep off, only a command can put the block to sleep
  assert_no_tmo_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !aslp_on && !sleep_cmd) |=> !sleep);
endmodule

bind wake_sleep_seq wsq_checker u_chk (
  .clk(clk), .rst(rst), .line_in(line_in), .sleep_cmd(sleep_cmd),
  .line_drive_low(line_drive_low), .sleep(sleep), .core_rst(core_rst),
  .aslp_on(aslp_on)
);

// File: tb/wake_sleep_seq_tb_top.sv
module wake_sleep_seq_tb_top;
  localparam int DG   = 8;
  localparam int POR  = 10;
  localparam int SRST = 12;
  localparam int IDLE = 200;
  localparam int BTS  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_line = 1'b1;
  logic [2:0] cfg_bits = 3'b100;
  logic ctl_wr = 1'b0, ctl_aslp = 1'b0, sleep_cmd = 1'b0, soft_rst_cmd = 1'b0;
  logic line_drive_low, sleep, core_rst, aslp_on;
  logic [1:0] spd_code;
  logic line_in;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign line_in = host_line & ~line_drive_low;

  wake_sleep_seq #(.DG_CYC(DG), .POR_CYC(POR), .SRST_CYC(SRST),
                   .IDLE_CYC(IDLE), .BT_SLOW_CYC(BTS), .SPD_W(2)) dut_i (
    .clk(clk), .rst(rst), .line_in(line_in), .cfg_bits(cfg_bits),
    .ctl_wr(ctl_wr), .ctl_aslp(ctl_aslp), .sleep_cmd(sleep_cmd),
    .soft_rst_cmd(soft_rst_cmd), .line_drive_low(line_drive_low),
    .sleep(sleep), .core_rst(core_rst), .aslp_on(aslp_on), .spd_code(spd_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=finish earlier", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_brk(int spd);
    int bt;
    bt = BTS >> spd;
    return (bt * 1391 + 500) / 1000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive the line low; release after 'hold' low samples (0 = keep low).
  task automatic do_wake(int hold, output int first_n, output int width, output int rst_at_brk);
    int n = 0;
    host_line = 1'b0;
    while (!line_drive_low && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (hold != 0 && n == hold) host_line = 1'b1;
    end
    first_n = n;
    rst_at_brk = core_rst;
    width = 0;
    while (line_drive_low && width < 1000) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic measure_tmo(logic lvl, output int n);
    host_line = lvl;
    n = 0;
    while (!sleep && n < IDLE + 50) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_cmd(logic s, logic r);
    sleep_cmd = s; soft_rst_cmd = r;
    @(negedge clk);
    sleep_cmd = 1'b0; soft_rst_cmd = 1'b0;
  endtask

  task automatic ctl_write(logic v);
    ctl_wr = 1'b1; ctl_aslp = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    int fn, w, ra, n;
    logic [2:0] cfg;
    void'($urandom(32'h5EED_1234));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sleep", sleep, 1);
    chk("R1 core_rst", core_rst, 1);
    chk("R1 drive", line_drive_low, 0);

    // R2: one sample short of the window
    idle(4);
    host_line = 1'b0;
    idle(DG - 1);
    host_line = 1'b1;
    idle(40);
    chk("R2 short pulse ignored", sleep, 1);
    chk("R2 no break", line_drive_low, 0);

    // Random wakes across configurations
    for (int it = 0; it < 8; it++) begin
      cfg = 3'($urandom);
      if (it < 4) cfg[1:0] = 2'(it);
      cfg_bits = cfg;
      host_line = 1'b1;
      idle(5);
      do_wake(DG + $urandom_range(0, POR - 1), fn, w, ra);
      chk("R2 R3 wake latency", fn, DG + POR);
      chk("R4 break width", w, exp_brk(int'(cfg[1:0])));
      chk("R4 speed code", int'(spd_code), int'(cfg[1:0]));
      chk("R5 core_rst at break", ra, 0);
      chk("R9 aslp_on", aslp_on, cfg[2]);
      cfg_bits = 3'($urandom);
      if (it % 2 == 0) begin
        idle(3);
        pulse_cmd(1'b1, 1'b0);
        chk("R10 sleep cmd", sleep, 1);
      end else if (cfg[2]) begin
        idle(3);
        measure_tmo(1'b0, n);
        chk_rng("R6 idle low timeout", n, IDLE, IDLE + 1);
        host_line = 1'b1;
      end else begin
        ctl_write(1'b1);
        chk("R8 permit off", aslp_on, 0);
        idle(3 * IDLE);
        chk("R8 no timeout", sleep, 0);
        pulse_cmd(1'b1, 1'b0);
        chk("R10 sleep cmd", sleep, 1);
      end
    end

    // Control disable, soft reset, then high-idle timeout
    cfg_bits = 3'b110;
    host_line = 1'b1;
    idle(5);
    do_wake(DG, fn, w, ra);
    chk("R4 slow break", w, exp_brk(2));
    ctl_write(1'b0);
    chk("R7 aslp_on off", aslp_on, 0);
    idle(3 * IDLE);
    chk("R7 no timeout", sleep, 0);
    cfg_bits = 3'b101;
    soft_rst_cmd = 1'b1;
    n = 0;
    while (!line_drive_low && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      soft_rst_cmd = 1'b0;
    end
    chk("R11 soft reset latency", n, SRST + 1);
    while (line_drive_low) @(negedge clk);
    chk("R9 reloaded after soft reset", aslp_on, 1);
    chk("R4 reloaded speed", int'(spd_code), 1);
    idle(2);
    host_line = 1'b0;
    idle(2);
    measure_tmo(1'b1, n);
    chk_rng("R6 idle high timeout", n, IDLE, IDLE + 1);

    // R12: line low into sleep
    cfg_bits = 3'b100;
    idle(3);
    do_wake(DG + 1, fn, w, ra);
    idle(2);
    measure_tmo(1'b0, n);
    chk_rng("R6 low idle", n, IDLE, IDLE + 1);
    idle(60);
    chk("R12 held low stays asleep", sleep, 1);
    host_line = 1'b1;
    idle(3);
    do_wake(DG, fn, w, ra);
    chk("R12 wake after rise", fn, DG + POR);

    // R3: host holds the line through the break
    pulse_cmd(1'b1, 1'b1);
    chk("R10 sleep beats soft reset", sleep, 1);
    idle(3);
    do_wake(0, fn, w, ra);
    chk("R3 no wait for line high", fn, DG + POR);
    host_line = 1'b1;
    idle(2);
    chk("R3 awake", sleep, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule